// File: doc/BRIEF.md
# Externally Clocked Serial Byte Receiver

This block gathers an 8-bit byte from a serial data pin, one bit for each pulse on an external clock pin. The external clock is not related to the system clock, so both pins pass through a two-stage synchroniser. An edge detector then drives a 17-state phase counter. Even phases wait for a rising edge, which samples a data bit. Odd phases wait for the falling edge that completes the bit.

When the eighth bit has completed, the block stops and raises an interrupt flag. A CPU read strobe for the register returns the byte, which is presented on `rx_byte`. The same read strobe lowers the flag and starts a new byte. A write strobe also starts a new byte, but it leaves the flag as it is. Either strobe given during a transfer drops the partial byte and starts the count again from the beginning.

Top module: `sr_serial_in`

## Requirements
- R1: After reset `rx_busy` is 0, `rx_irq` is 0 and `rx_byte` is 0x00.
- R2: Both pins are synchronised through two flip-flops. A level change on `ser_clk` and `ser_dat` made just after a system clock edge has no effect on `rx_byte` after two more edges. It is shifted in after the third edge.
- R3: Each bit sampled enters at bit 0 and earlier bits move toward bit 7, so the first bit received ends at bit 7 of `rx_byte`.
- R4: A phase counter runs from 0 to 16 and advances once per synchronised clock edge: rising edges in even phases and falling edges in odd phases. `rx_busy` is 1 while the phase is below 16, so it stays 1 after the eighth rising edge and drops only with the eighth falling edge.
- R5: `rx_irq` is set in the cycle the phase counter reaches 16.
- R6: A pulse on `sr_rd` clears `rx_irq` and `rx_byte` and sets the phase to 0, so `rx_busy` is 1 on the next cycle.
- R7: A pulse on `sr_wr` sets the phase to 0 and clears `rx_byte`, but it leaves `rx_irq` unchanged.
- R8: While idle (phase 16), edges on `ser_clk` are ignored. `rx_byte`, `rx_irq` and `rx_busy` hold their values until the next strobe.
- R9: A strobe during a transfer resets the phase to 0 and discards the partial byte. The byte that follows is built only from bits received after the strobe.
- R10: A falling edge that arrives in an even phase is ignored. This happens when a strobe is given while `ser_clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | External shift clock pin |
| ser_dat | input | 1 | Serial data pin |
| sr_rd | input | 1 | Read strobe for the shift register address |
| sr_wr | input | 1 | Write strobe for the shift register address |
| rx_byte | output | 8 | Received byte |
| rx_irq | output | 1 | Byte-complete interrupt flag |
| rx_busy | output | 1 | Transfer in progress (phase below 16) |

## Verification
The hardest situation to reach from the ports is a clock edge whose phase parity does not match its direction: a falling edge arriving while the counter waits for a rising one. The stimulus creates it by raising `ser_clk` while the block is idle, giving a read strobe, and only then lowering the clock. Random bytes follow, to show that the stray edge did not shift the bit framing. Aborted transfers and extra clocks after completion are mixed in among random bytes, so the cases that lose data are exercised against a bench model of the shift sequence.

// File: rtl/sr_serial_in_pkg.sv
package sr_serial_in_pkg;

    // Synchronised edge events of the external shift clock.
    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    // Kind of CPU access seen in a cycle.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    function automatic acc_kind_t decode_access(input logic rd, input logic wr);
        if (rd)      return ACC_READ;
        else if (wr) return ACC_WRITE;
        else         return ACC_NONE;
    endfunction

    // Number of phases in a full byte: two per bit.
    function automatic int unsigned phase_span(input int unsigned bits);
        return 2 * bits;
    endfunction

endpackage

// File: rtl/sr_sync_edge.sv
module sr_sync_edge
    import sr_serial_in_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_in,
    input  logic      sdat_in,
    output sclk_evt_t evt,
    output logic      sdat_s
);
    logic [STAGES-1:0] ck_q;
    logic [STAGES-1:0] dt_q;
    logic              ck_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_q <= '0;
                    dt_q <= '0;
                end else begin
                    ck_q <= sclk_in;
                    dt_q <= sdat_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_q <= '0;
                    dt_q <= '0;
                end else begin
                    ck_q <= {ck_q[STAGES-2:0], sclk_in};
                    dt_q <= {dt_q[STAGES-2:0], sdat_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ck_prev <= 1'b0;
        else     ck_prev <= ck_q[STAGES-1];
    end

    always_comb begin
        evt.rise = ck_q[STAGES-1] & ~ck_prev;
        evt.fall = ~ck_q[STAGES-1] & ck_prev;
        sdat_s   = dt_q[STAGES-1];
    end
endmodule

// File: rtl/sr_phase_ctr.sv
module sr_phase_ctr
    import sr_serial_in_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PH_DONE = phase_span(DATA_W),
    localparam int unsigned PH_W = $clog2(PH_DONE + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  sclk_evt_t       evt,
    output logic [PH_W-1:0] phase,
    output logic            shift_en,
    output logic            done_pulse
);
    logic active;
    logic even_ph;
    logic adv_fall;

    always_comb begin
        active     = (phase != PH_W'(PH_DONE));
        even_ph    = ~phase[0];
        shift_en   = !restart && active && even_ph && evt.rise;
        adv_fall   = !restart && active && !even_ph && evt.fall;
        done_pulse = adv_fall && (phase == PH_W'(PH_DONE - 1));
    end

    always_ff @(posedge clk) begin
        if (rst)                       phase <= PH_W'(PH_DONE);
        else if (restart)              phase <= '0;
        else if (shift_en || adv_fall) phase <= phase + PH_W'(1);
    end
endmodule

// File: rtl/sr_data_reg.sv
module sr_data_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst || clear) data <= '0;
        else if (shift_en) data <= {data[DATA_W-2:0], bit_in};
    end
endmodule

// File: rtl/sr_serial_in.sv
module sr_serial_in
    import sr_serial_in_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PH_DONE = phase_span(DATA_W),
    localparam int unsigned PH_W = $clog2(PH_DONE + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              sr_rd,
    input  logic              sr_wr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_irq,
    output logic              rx_busy
);
    sclk_evt_t       evt;
    logic            sdat_s;
    logic [PH_W-1:0] phase;
    logic            shift_en;
    logic            done_pulse;
    acc_kind_t       acc;
    logic            restart;

    always_comb begin
        acc     = decode_access(sr_rd, sr_wr);
        restart = (acc != ACC_NONE);
    end

    sr_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .sclk_in(ser_clk), .sdat_in(ser_dat),
        .evt(evt), .sdat_s(sdat_s)
    );

    sr_phase_ctr #(.DATA_W(DATA_W)) ctr_i (
        .clk(clk), .rst(rst), .restart(restart), .evt(evt),
        .phase(phase), .shift_en(shift_en), .done_pulse(done_pulse)
    );

    sr_data_reg #(.DATA_W(DATA_W)) dreg_i (
        .clk(clk), .rst(rst), .clear(restart), .shift_en(shift_en),
        .bit_in(sdat_s), .data(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst)                 rx_irq <= 1'b0;
        else if (acc == ACC_READ) rx_irq <= 1'b0;
        else if (done_pulse)     rx_irq <= 1'b1;
    end

    assign rx_busy = (phase != PH_W'(PH_DONE));
endmodule

// File: rtl/sr_serial_in_chk.sv
module sr_serial_in_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sr_rd,
    input logic              sr_wr,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_irq,
    input logic              rx_busy
);
    // R1: reset leaves the block idle with a clear flag and byte
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!rx_busy && !rx_irq && rx_byte == '0));

    // R6: a read drops the flag and starts a transfer
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        sr_rd |=> (!rx_irq && rx_busy));

    // R7: a write starts a transfer without touching the flag
    a_r7_write_keeps_flag: assert property (@(posedge clk) disable iff (rst)
        (sr_wr && !sr_rd) |=> (rx_busy && rx_irq == $past(rx_irq)));

    // R5: the flag only rises as the transfer finishes
    a_r5_flag_at_done: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> (!rx_busy && $fell(rx_busy)));

    // R8: while idle and untouched, nothing moves
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!rx_busy && !sr_rd && !sr_wr) |=>
            (!rx_busy && $stable(rx_byte) && $stable(rx_irq)));
endmodule

bind sr_serial_in sr_serial_in_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .sr_rd(sr_rd), .sr_wr(sr_wr),
    .rx_byte(rx_byte), .rx_irq(rx_irq), .rx_busy(rx_busy)
);

// File: tb/sr_serial_in_tb.sv
`timescale 1ns/1ps
module sr_serial_in_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       sr_rd = 1'b0;
    logic       sr_wr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_irq;
    logic       rx_busy;

    int tests = 0;
    int fails = 0;
    logic [7:0] model;

    always #2.5 clk = ~clk;

    sr_serial_in dut_i (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .sr_rd(sr_rd), .sr_wr(sr_wr), .rx_byte(rx_byte),
        .rx_irq(rx_irq), .rx_busy(rx_busy)
    );

    function automatic logic [7:0] shift_model(input logic [7:0] cur, input logic b);
        return {cur[6:0], b};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input bit rd);
        if (rd) sr_rd = 1'b1; else sr_wr = 1'b1;
        @(negedge clk);
        sr_rd = 1'b0;
        sr_wr = 1'b0;
        model = 8'h00;
    endtask

    task automatic clk_rise(input logic b);
        ser_dat = b;
        idle(2);
        ser_clk = 1'b1;
        idle(5);
    endtask

    task automatic clk_fall();
        ser_clk = 1'b0;
        idle(5);
    endtask

    task automatic send_bit(input logic b);
        clk_rise(b);
        clk_fall();
        model = shift_model(model, b);
    endtask

    // Send a whole byte first bit = MSB and check framing.
    task automatic send_byte(input logic [7:0] v, input string tag);
        for (int i = 7; i >= 1; i--) send_bit(v[i]);
        clk_rise(v[0]);
        model = shift_model(model, v[0]);
        chk(rx_busy === 1'b1 && rx_irq === 1'b0, {tag, " R4 busy before last fall"},
            {30'd0, rx_busy, rx_irq}, 32'h2);
        clk_fall();
        chk(rx_busy === 1'b0, {tag, " R4 idle after last fall"}, rx_busy, 0);
        chk(rx_irq === 1'b1, {tag, " R5 flag at done"}, rx_irq, 1);
        chk(rx_byte === model && model == v, {tag, " R3 byte order"}, rx_byte, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] held;
        void'($urandom(32'h1A2B3C4D));
        model = 8'h00;
        idle(3);
        rst = 1'b0;
        idle(1);
        chk(rx_busy === 1'b0 && rx_irq === 1'b0 && rx_byte === 8'h00, "R1 reset state",
            {rx_byte, 6'd0, rx_busy, rx_irq}, 0);

        // R8: edges while idle after reset are ignored
        send_bit(1'b1);
        chk(rx_busy === 1'b0 && rx_byte === 8'h00, "R8 idle edge after reset",
            {rx_byte, 7'd0, rx_busy}, 0);

        // R2: synchroniser latency
        strobe(1'b1);
        chk(rx_busy === 1'b1 && rx_irq === 1'b0, "R6 read starts", {rx_busy, rx_irq}, 2);
        ser_dat = 1'b1;
        ser_clk = 1'b1;
        idle(2);
        chk(rx_byte === 8'h00, "R2 not yet shifted after two edges", rx_byte, 0);
        idle(1);
        chk(rx_byte === 8'h01, "R2 shifted after third edge", rx_byte, 1);
        idle(3);
        clk_fall();
        model = 8'h01;

        // R9: abort mid transfer
        send_bit(1'b0);
        send_bit(1'b1);
        strobe(1'b1);
        chk(rx_byte === 8'h00 && rx_busy === 1'b1, "R9 partial byte dropped",
            {rx_byte, 7'd0, rx_busy}, 1);
        send_byte(8'hA5, "abort");

        // Random bytes, with extra ignored clocks after each
        for (int k = 0; k < 8; k++) begin
            v = 8'($urandom);
            strobe(1'b1);
            chk(rx_irq === 1'b0 && rx_busy === 1'b1, "R6 read clears flag",
                {rx_irq, rx_busy}, 1);
            send_byte(v, "rand");
            held = rx_byte;
            for (int j = 0; j < 3; j++) send_bit(1'($urandom));
            chk(rx_byte === held && rx_irq === 1'b1 && rx_busy === 1'b0,
                "R8 extra clocks ignored", rx_byte, held);
        end

        // R7: write restarts but keeps the flag
        strobe(1'b0);
        chk(rx_busy === 1'b1 && rx_irq === 1'b1 && rx_byte === 8'h00,
            "R7 write keeps flag", {rx_byte, 6'd0, rx_busy, rx_irq}, 3);
        v = 8'h3C;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        chk(rx_byte === v && rx_busy === 1'b0, "R7 byte after write", rx_byte, v);

        // R10: strobe while clock high, then a falling edge in an even phase
        ser_clk = 1'b1;
        idle(5);
        strobe(1'b1);
        clk_fall();
        chk(rx_busy === 1'b1 && rx_byte === 8'h00, "R10 stray fall ignored",
            {rx_byte, 7'd0, rx_busy}, 1);
        send_byte(8'h81, "R10");

        // R9: abort with a write after five bits
        for (int j = 0; j < 5; j++) send_bit(1'b1);
        strobe(1'b1);
        for (int j = 0; j < 5; j++) send_bit(1'b1);
        strobe(1'b0);
        send_byte(8'h5A, "R9 write abort");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule